// File: doc/BRIEF.md
# Sleep Mode Wake-up Controller

This block manages the low-power states of a small microcontroller core. When the core issues a sleep request, the controller captures a 3-bit mode field together with a sleep-enable bit. From the captured mode it decides which clocks to stop: the CPU clock, the I/O clock, the main oscillator, the timer's dedicated oscillator, and the synchronous clock feed to that timer. The block runs on an always-running low-frequency clock, so it keeps working while the core is stopped.

While asleep it watches a set of wake sources: external interrupt lines, a pin-change event, and the overflow and compare events of an asynchronous timer. Every source first passes through a two-flop synchronizer. Which sources may wake the core depends on the mode. After a wake event the controller waits for a start-up period and then re-enables the core clock. This period is chosen by a clock-select configuration input, except in Standby, which uses a fixed six cycles. A one-cycle acknowledge pulse marks the first cycle in which the core clock runs again.

External lines can be marked level-triggered. Such a line still wakes the device if it drops during start-up, but its interrupt request is not passed to the core.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: During and straight after reset the controller is running: cpu_clk_en, io_clk_en and osc_en are 1, wake_ack is 0 and ext_irq_req is 0.
- R2: A sleep request is ignored, and cpu_clk_en stays 1, when sleep_en is 0 or when mode_in is none of 3'b010 (Power-down), 3'b011 (Power-save) or 3'b110 (Standby).
- R3: Mode 3'b110 is accepted only when xtal_cfg is 1, and is otherwise ignored. While in Standby sleep: cpu_clk_en=0, io_clk_en=0, osc_en=1, tosc_en=0, tmr_sclk_en=0.
- R4: While in Power-down sleep, all five clock enables are 0. cpu_clk_en and io_clk_en are always gated together.
- R5: While in Power-save sleep, cpu_clk_en and io_clk_en are 0. With tmr_en=1 and tmr_async=1: tosc_en=1, osc_en=0, tmr_sclk_en=0. With tmr_en=1 and tmr_async=0: tosc_en=0, osc_en=1, tmr_sclk_en=1. With tmr_en=0, all three are 0. While running: tosc_en=tmr_en&tmr_async and tmr_sclk_en=tmr_en&~tmr_async.
- R6: An external line or a pin-change event wakes the core in every sleep mode. A timer overflow or compare event wakes it only in Power-save, only with tmr_en=1 and gie=1, and only with that event's own enable (ovf_ie or cmp_ie) set. Otherwise the core stays asleep.
- R7: In Power-down and Power-save, wake_ack is sampled high N+3 clock edges after a wake input rises, where N = STARTUP_UNIT*4^cksel (4, 16, 64 or 256 by default).
- R8: In Standby the wake latency is a fixed 6+3 = 9 edges, whatever cksel holds.
- R9: During the start-up period osc_en is 1 and cpu_clk_en is 0.
- R10: wake_ack is high for exactly one cycle, in the first cycle with cpu_clk_en=1. The controller is running on the next cycle.
- R11: ext_irq_req[i] pulses together with wake_ack when line i was seen high during sleep. For a level-triggered line (ext_level[i]=1), this needs the line still high two edges before the end of start-up. If it dropped earlier, the core wakes with ext_irq_req[i]=0. An edge-type line keeps its request even if it drops early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running low-frequency clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle sleep request from the core |
| sleep_en | input | 1 | Sleep-enable bit captured with the request |
| mode_in | input | 3 | Sleep mode field |
| xtal_cfg | input | 1 | External crystal or resonator clock option selected |
| cksel | input | 2 | Clock-select configuration for the start-up length |
| tmr_en | input | 1 | Asynchronous timer enabled |
| tmr_async | input | 1 | Timer clocked from its own oscillator (1) or the synchronous clock (0) |
| ovf_ie | input | 1 | Timer overflow interrupt enable |
| cmp_ie | input | 1 | Timer compare interrupt enable |
| gie | input | 1 | Global interrupt enable |
| ext_irq | input | NUM_EXT | External interrupt lines (asynchronous) |
| ext_level | input | NUM_EXT | 1 marks the matching line as level-triggered |
| pc_evt | input | 1 | Pin-change event (asynchronous) |
| tmr_ovf | input | 1 | Timer overflow event (asynchronous) |
| tmr_cmp | input | 1 | Timer compare event (asynchronous) |
| cpu_clk_en | output | 1 | CPU clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| osc_en | output | 1 | Main oscillator enable |
| tosc_en | output | 1 | Timer dedicated oscillator enable |
| tmr_sclk_en | output | 1 | Synchronous clock feed to the timer |
| wake_ack | output | 1 | One-cycle pulse when the core clock resumes |
| ext_irq_req | output | NUM_EXT | Interrupt requests passed to the core at wake-up |

## Verification
The critical coincidence is a level-triggered line that drops just as the start-up count expires. The edge that moves the controller into the wake cycle also makes the final decision on that line's interrupt request. The bench raises a level line in Power-down with the shortest start-up period and releases it either one edge too early or just in time. In both cases the wake latency must stay unchanged, and only ext_irq_req must flip between 0 and 1. A second case drops an edge-type line in the same way and expects its request to survive.

// File: rtl/slpw_pkg.sv
package slpw_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SLEEP,
        ST_STARTUP,
        ST_WAKE
    } slpw_state_e;

    typedef enum logic [1:0] {
        SM_PDOWN,
        SM_PSAVE,
        SM_STBY
    } sleep_kind_e;

    typedef struct packed {
        logic cpu;
        logic io;
        logic osc;
        logic tosc;
        logic tsclk;
    } clk_en_t;

    localparam logic [2:0] MODE_PDOWN = 3'b010;
    localparam logic [2:0] MODE_PSAVE = 3'b011;
    localparam logic [2:0] MODE_STBY  = 3'b110;

    function automatic logic slpw_mode_ok(input logic [2:0] mode, input logic xtal);
        return (mode == MODE_PDOWN) || (mode == MODE_PSAVE) ||
               ((mode == MODE_STBY) && xtal);
    endfunction

    function automatic sleep_kind_e slpw_decode(input logic [2:0] mode);
        case (mode)
            MODE_PSAVE: return SM_PSAVE;
            MODE_STBY:  return SM_STBY;
            default:    return SM_PDOWN;
        endcase
    endfunction

    function automatic int unsigned slpw_startup_len(input int unsigned unit,
                                                     input logic [1:0] sel);
        return unit << (2 * int'(sel));
    endfunction

endpackage

// File: rtl/slpw_sync.sv
module slpw_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/slpw_fsm.sv
module slpw_fsm
    import slpw_pkg::*;
#(
    parameter int STARTUP_UNIT = 4,
    parameter int STBY_CYC     = 6,
    parameter int CNT_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_req,
    input  logic              sleep_en,
    input  logic [2:0]        mode_in,
    input  logic              xtal_cfg,
    input  logic [1:0]        cksel,
    input  logic              wake_any,
    output slpw_state_e       state,
    output sleep_kind_e       kind
);
    localparam logic [CNT_W-1:0] STBY_LAST = CNT_W'(STBY_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        if (kind == SM_STBY)
            load_val = STBY_LAST;
        else
            load_val = CNT_W'(slpw_startup_len(STARTUP_UNIT, cksel) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            kind  <= SM_PDOWN;
            cnt   <= '0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (sleep_req && sleep_en && slpw_mode_ok(mode_in, xtal_cfg)) begin
                        state <= ST_SLEEP;
                        kind  <= slpw_decode(mode_in);
                    end
                end
                ST_SLEEP: begin
                    if (wake_any) begin
                        state <= ST_STARTUP;
                        cnt   <= load_val;
                    end
                end
                ST_STARTUP: begin
                    if (cnt == '0)
                        state <= ST_WAKE;
                    else
                        cnt <= cnt - 1'b1;
                end
                ST_WAKE: begin
                    state <= ST_RUN;
                end
                default: state <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/slpw_wake_qual.sv
module slpw_wake_qual
    import slpw_pkg::*;
#(
    parameter int NUM_EXT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  slpw_state_e        state,
    input  sleep_kind_e        kind,
    input  logic [NUM_EXT-1:0] s_ext,
    input  logic [NUM_EXT-1:0] ext_level,
    input  logic               s_pc,
    input  logic               s_ovf,
    input  logic               s_cmp,
    input  logic               tmr_en,
    input  logic               ovf_ie,
    input  logic               cmp_ie,
    input  logic               gie,
    output logic               wake_any,
    output logic [NUM_EXT-1:0] ext_req
);
    logic               tmr_wake;
    logic               asleep;
    logic [NUM_EXT-1:0] pend;

    assign asleep   = (state == ST_SLEEP) || (state == ST_STARTUP);
    assign tmr_wake = (kind == SM_PSAVE) && tmr_en && gie &&
                      ((s_ovf && ovf_ie) || (s_cmp && cmp_ie));
    assign wake_any = (|s_ext) || s_pc || tmr_wake;

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[i] <= 1'b0;
            end else if (asleep) begin
                if (ext_level[i])
                    pend[i] <= s_ext[i];
                else
                    pend[i] <= pend[i] | s_ext[i];
            end else if (state == ST_RUN) begin
                pend[i] <= 1'b0;
            end
        end
        assign ext_req[i] = (state == ST_WAKE) && pend[i];
    end
endmodule

// File: rtl/slpw_clkgate.sv
module slpw_clkgate
    import slpw_pkg::*;
(
    input  slpw_state_e state,
    input  sleep_kind_e kind,
    input  logic        tmr_en,
    input  logic        tmr_async,
    output clk_en_t     en
);
    logic tmr_on_osc;
    logic tmr_on_sync;

    assign tmr_on_osc  = tmr_en && tmr_async;
    assign tmr_on_sync = tmr_en && !tmr_async;

    always_comb begin
        en.cpu   = 1'b1;
        en.io    = 1'b1;
        en.osc   = 1'b1;
        en.tosc  = tmr_on_osc;
        en.tsclk = tmr_on_sync;
        if ((state == ST_SLEEP) || (state == ST_STARTUP)) begin
            en.cpu = 1'b0;
            en.io  = 1'b0;
            case (kind)
                SM_PSAVE: begin
                    en.osc   = tmr_on_sync;
                    en.tosc  = tmr_on_osc;
                    en.tsclk = tmr_on_sync;
                end
                SM_STBY: begin
                    en.osc   = 1'b1;
                    en.tosc  = 1'b0;
                    en.tsclk = 1'b0;
                end
                default: begin
                    en.osc   = 1'b0;
                    en.tosc  = 1'b0;
                    en.tsclk = 1'b0;
                end
            endcase
            if (state == ST_STARTUP)
                en.osc = 1'b1;
        end
    end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import slpw_pkg::*;
#(
    parameter int NUM_EXT      = 2,
    parameter int STARTUP_UNIT = 4,
    parameter int STBY_CYC     = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep_req,
    input  logic               sleep_en,
    input  logic [2:0]         mode_in,
    input  logic               xtal_cfg,
    input  logic [1:0]         cksel,
    input  logic               tmr_en,
    input  logic               tmr_async,
    input  logic               ovf_ie,
    input  logic               cmp_ie,
    input  logic               gie,
    input  logic [NUM_EXT-1:0] ext_irq,
    input  logic [NUM_EXT-1:0] ext_level,
    input  logic               pc_evt,
    input  logic               tmr_ovf,
    input  logic               tmr_cmp,
    output logic               cpu_clk_en,
    output logic               io_clk_en,
    output logic               osc_en,
    output logic               tosc_en,
    output logic               tmr_sclk_en,
    output logic               wake_ack,
    output logic [NUM_EXT-1:0] ext_irq_req
);
    localparam int SYNC_W  = NUM_EXT + 3;
    localparam int MAX_LEN = (STARTUP_UNIT * 64 > STBY_CYC) ? STARTUP_UNIT * 64 : STBY_CYC;
    localparam int CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

    logic [SYNC_W-1:0] raw_src;
    logic [SYNC_W-1:0] sync_src;
    slpw_state_e       state_q;
    sleep_kind_e       kind_q;
    logic              wake_any;
    clk_en_t           gate;

    assign raw_src = {tmr_cmp, tmr_ovf, pc_evt, ext_irq};

    slpw_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_src),
        .q   (sync_src)
    );

    slpw_wake_qual #(.NUM_EXT(NUM_EXT)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .state     (state_q),
        .kind      (kind_q),
        .s_ext     (sync_src[NUM_EXT-1:0]),
        .ext_level (ext_level),
        .s_pc      (sync_src[NUM_EXT]),
        .s_ovf     (sync_src[NUM_EXT+1]),
        .s_cmp     (sync_src[NUM_EXT+2]),
        .tmr_en    (tmr_en),
        .ovf_ie    (ovf_ie),
        .cmp_ie    (cmp_ie),
        .gie       (gie),
        .wake_any  (wake_any),
        .ext_req   (ext_irq_req)
    );

    slpw_fsm #(
        .STARTUP_UNIT (STARTUP_UNIT),
        .STBY_CYC     (STBY_CYC),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .sleep_en  (sleep_en),
        .mode_in   (mode_in),
        .xtal_cfg  (xtal_cfg),
        .cksel     (cksel),
        .wake_any  (wake_any),
        .state     (state_q),
        .kind      (kind_q)
    );

    slpw_clkgate u_gate (
        .state     (state_q),
        .kind      (kind_q),
        .tmr_en    (tmr_en),
        .tmr_async (tmr_async),
        .en        (gate)
    );

    assign cpu_clk_en  = gate.cpu;
    assign io_clk_en   = gate.io;
    assign osc_en      = gate.osc;
    assign tosc_en     = gate.tosc;
    assign tmr_sclk_en = gate.tsclk;
    assign wake_ack    = (state_q == ST_WAKE);
endmodule

// File: rtl/slpw_checker.sv
module slpw_checker
    import slpw_pkg::*;
#(
    parameter int NUM_EXT = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               sleep_req,
    input logic               sleep_en,
    input logic               cpu_clk_en,
    input logic               io_clk_en,
    input logic               osc_en,
    input logic               wake_ack,
    input logic [NUM_EXT-1:0] ext_irq_req,
    input slpw_state_e        state_q
);
    // R10: acknowledge lasts one cycle
    p_ack_single_r10: assert property (@(posedge clk) disable iff (rst)
        wake_ack |=> !wake_ack);

    // R10: acknowledge coincides with a running core clock
    p_ack_cpu_r10: assert property (@(posedge clk) disable iff (rst)
        wake_ack |-> cpu_clk_en);

    // R7: the core clock only comes back through a wake cycle
    p_rose_ack_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> wake_ack);

    // R4: CPU and I/O clocks stop together
    p_gate_pair_r4: assert property (@(posedge clk) disable iff (rst)
        !cpu_clk_en |-> !io_clk_en);

    // R9: oscillator restarts during the start-up count
    p_startup_osc_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STARTUP) |-> (osc_en && !cpu_clk_en));

    // R11: interrupt requests reach the core only in the wake cycle
    p_irq_at_ack_r11: assert property (@(posedge clk) disable iff (rst)
        (|ext_irq_req) |-> wake_ack);

    // R2: a request without sleep enable keeps the core running
    p_ignore_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && !wake_ack && sleep_req && !sleep_en) |=> cpu_clk_en);
endmodule

bind sleep_wake_ctrl slpw_checker #(.NUM_EXT(NUM_EXT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sleep_req   (sleep_req),
    .sleep_en    (sleep_en),
    .cpu_clk_en  (cpu_clk_en),
    .io_clk_en   (io_clk_en),
    .osc_en      (osc_en),
    .wake_ack    (wake_ack),
    .ext_irq_req (ext_irq_req),
    .state_q     (state_q)
);

// File: tb/sleep_wake_ctrl_test.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       sleep_req = 1'b0;
    logic       sleep_en = 1'b0;
    logic [2:0] mode_in = 3'b000;
    logic       xtal_cfg = 1'b0;
    logic [1:0] cksel = 2'd0;
    logic       tmr_en = 1'b0;
    logic       tmr_async = 1'b0;
    logic       ovf_ie = 1'b0;
    logic       cmp_ie = 1'b0;
    logic       gie = 1'b0;
    logic [1:0] ext_level = 2'b00;
    logic [4:0] src_drv = 5'b0;
    logic       cpu_clk_en, io_clk_en, osc_en, tosc_en, tmr_sclk_en, wake_ack;
    logic [1:0] ext_irq_req;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    sleep_wake_ctrl uut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_en(sleep_en),
        .mode_in(mode_in), .xtal_cfg(xtal_cfg), .cksel(cksel),
        .tmr_en(tmr_en), .tmr_async(tmr_async), .ovf_ie(ovf_ie),
        .cmp_ie(cmp_ie), .gie(gie), .ext_irq(src_drv[1:0]),
        .ext_level(ext_level), .pc_evt(src_drv[2]), .tmr_ovf(src_drv[3]),
        .tmr_cmp(src_drv[4]), .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en),
        .osc_en(osc_en), .tosc_en(tosc_en), .tmr_sclk_en(tmr_sclk_en),
        .wake_ack(wake_ack), .ext_irq_req(ext_irq_req)
    );

    // {mode[2:0], sleep_en, xtal, tmr_en, tmr_async, sleeps, osc, tosc, tsclk}
    localparam logic [10:0] VEC [10] = '{
        {3'b010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'b011, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {3'b011, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {3'b011, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'b110, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'b110, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {3'b101, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'b000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {3'b010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic enter_sleep(input logic [2:0] m, input logic en);
        @(negedge clk);
        mode_in   = m;
        sleep_en  = en;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic run_wake(input int src, input int drop_at,
                            output int cnt, output logic [1:0] req);
        cnt = 0;
        req = 2'b00;
        src_drv[src] = 1'b1;
        while (cnt < 3000) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (drop_at != 0 && cnt == drop_at) src_drv[src] = 1'b0;
            if (wake_ack) begin
                req = ext_irq_req;
                break;
            end
        end
        src_drv[src] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int          cnt;
        logic [1:0]  req;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 cpu_clk_en in reset", int'(cpu_clk_en), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cpu_clk_en", int'(cpu_clk_en), 1);
        chk("R1 io_clk_en", int'(io_clk_en), 1);
        chk("R1 osc_en", int'(osc_en), 1);
        chk("R1 wake_ack", int'(wake_ack), 0);
        chk("R1 ext_irq_req", int'(ext_irq_req), 0);

        // Table walk: R2, R3, R4, R5
        for (int v = 0; v < 10; v++) begin
            logic [10:0] e;
            e = VEC[v];
            xtal_cfg  = e[6];
            tmr_en    = e[5];
            tmr_async = e[4];
            enter_sleep(e[10:8], e[7]);
            chk($sformatf("R2/R3/R4/R5 vec%0d cpu_clk_en", v), int'(cpu_clk_en), int'(!e[3]));
            chk($sformatf("R4 vec%0d io_clk_en", v), int'(io_clk_en), int'(!e[3]));
            chk($sformatf("R5 vec%0d osc_en", v), int'(osc_en), int'(e[2]));
            chk($sformatf("R5 vec%0d tosc_en", v), int'(tosc_en), int'(e[1]));
            chk($sformatf("R5 vec%0d tmr_sclk_en", v), int'(tmr_sclk_en), int'(e[0]));
            if (e[3]) begin
                run_wake(0, 0, cnt, req);
                chk($sformatf("R6 vec%0d woke by ext line", v), int'(cpu_clk_en), 1);
            end
        end
        xtal_cfg = 1'b0;
        tmr_en = 1'b0;
        tmr_async = 1'b0;

        // R7: Power-down latency for each clock select
        for (int s = 0; s < 4; s++) begin
            cksel = 2'(s);
            enter_sleep(3'b010, 1'b1);
            run_wake(0, 0, cnt, req);
            chk($sformatf("R7 latency cksel=%0d", s), cnt, (4 << (2 * s)) + 3);
        end

        // R8: Standby latency ignores cksel
        xtal_cfg = 1'b1;
        cksel = 2'd3;
        enter_sleep(3'b110, 1'b1);
        run_wake(2, 0, cnt, req);
        chk("R8 standby latency, pin change wake", cnt, 9);
        xtal_cfg = 1'b0;

        // R9 / R10: mid start-up and around the acknowledge
        cksel = 2'd1;
        enter_sleep(3'b010, 1'b1);
        src_drv[0] = 1'b1;
        repeat (8) @(negedge clk);
        chk("R9 osc_en during start-up", int'(osc_en), 1);
        chk("R9 cpu_clk_en during start-up", int'(cpu_clk_en), 0);
        while (!wake_ack) @(negedge clk);
        chk("R10 cpu_clk_en with ack", int'(cpu_clk_en), 1);
        @(negedge clk);
        chk("R10 ack drops after one cycle", int'(wake_ack), 0);
        chk("R10 running after ack", int'(cpu_clk_en), 1);
        src_drv[0] = 1'b0;
        repeat (4) @(negedge clk);

        // R6: timer events
        cksel = 2'd0;
        tmr_en = 1'b1;
        tmr_async = 1'b1;
        ovf_ie = 1'b1;
        cmp_ie = 1'b1;
        gie = 1'b1;
        enter_sleep(3'b010, 1'b1);
        src_drv[3] = 1'b1;
        repeat (12) @(negedge clk);
        chk("R6 overflow ignored in Power-down", int'(cpu_clk_en), 0);
        src_drv[3] = 1'b0;
        repeat (4) @(negedge clk);
        run_wake(1, 0, cnt, req);

        gie = 1'b0;
        enter_sleep(3'b011, 1'b1);
        src_drv[3] = 1'b1;
        repeat (12) @(negedge clk);
        chk("R6 overflow ignored without gie", int'(cpu_clk_en), 0);
        src_drv[3] = 1'b0;
        repeat (4) @(negedge clk);
        gie = 1'b1;
        run_wake(3, 0, cnt, req);
        chk("R6/R7 overflow wakes Power-save", cnt, 7);

        cmp_ie = 1'b0;
        enter_sleep(3'b011, 1'b1);
        src_drv[4] = 1'b1;
        repeat (12) @(negedge clk);
        chk("R6 compare ignored without cmp_ie", int'(cpu_clk_en), 0);
        src_drv[4] = 1'b0;
        repeat (4) @(negedge clk);
        cmp_ie = 1'b1;
        run_wake(4, 0, cnt, req);
        chk("R6 compare wakes Power-save", cnt, 7);
        tmr_en = 1'b0;
        tmr_async = 1'b0;

        // R11: level line drop racing the end of start-up (N=4, ack at 7)
        ext_level = 2'b01;
        enter_sleep(3'b010, 1'b1);
        run_wake(0, 4, cnt, req);
        chk("R11 level dropped early still wakes", cnt, 7);
        chk("R11 level dropped early no request", int'(req), 0);
        enter_sleep(3'b010, 1'b1);
        run_wake(0, 5, cnt, req);
        chk("R11 level held long enough", cnt, 7);
        chk("R11 level held gives request", int'(req), 1);
        ext_level = 2'b00;
        enter_sleep(3'b010, 1'b1);
        run_wake(0, 2, cnt, req);
        chk("R11 edge line keeps request", int'(req), 1);
        enter_sleep(3'b010, 1'b1);
        run_wake(1, 0, cnt, req);
        chk("R11 request on line 1 only", int'(req), 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule